// File: doc/BRIEF.md
# Coherence Ack Count Accumulator

This block keeps the tally that an outstanding request for write permission must settle before it can complete. Two kinds of response reach it: a data response that carries a signed count of invalidation acknowledgements still to come, and single acknowledgements from sharers that have dropped their copy. Acknowledgements can arrive before the data response that says how many to expect. The tally is therefore a signed running sum that goes negative while early acknowledgements wait for the data.

The controller opens a tally with an allocate strobe and can abandon it with a clear strobe. Each response produces a registered event code one cycle later. The code tells whether the response closed the transaction or left it open. A closing response also raises a one-cycle completion pulse and sends the tally back to idle. Responses that arrive while idle, in the same cycle as each other, or that would push the tally out of its signed range are refused and raise a sticky error flag.

Top module: `ack_count_accum`

## Requirements
- R1: During and right after reset, busy_o, done_o, err_o and evt_vld_o are 0, pending_o is 0 and evt_code_o is 0 (no event).
- R2: An alloc_i pulse without clear_i makes busy_o 1, pending_o 0 and err_o 0 at the next edge, and emits no event.
- R3: While busy, a data response with count 0 yields code 1 (data, closing) and completes at once, whatever the pending value.
- R4: While busy, a data response with a nonzero count N closes the transaction with code 3 when N plus the pending value is 0.
- R5: While busy, a data response with a nonzero count whose sum with the pending value is nonzero and within range yields code 2 (data, open), and that sum becomes the new pending value.
- R6: While busy, an acknowledgement yields code 5 (ack, closing) and completes when the pending value is exactly 1.
- R7: While busy, an acknowledgement with the pending value not 1 yields code 4 (ack, open) and lowers the pending value by one, so that it can go below zero.
- R8: A closing event raises done_o for exactly one cycle, together with busy_o 0 and pending_o 0. Later responses are refused until the next allocate.
- R9: A response presented while idle is refused. It yields code 6, sets err_o and leaves pending_o and busy_o unchanged.
- R10: A response whose result would leave the range -MAX_SHARERS..+MAX_SHARERS yields code 7, sets err_o, and leaves pending_o unchanged with the tally still busy.
- R11: A data response and an acknowledgement in the same cycle yield code 6, set err_o and change nothing else.
- R12: clear_i, which outranks alloc_i, returns the tally to idle with pending_o 0 and leaves err_o as it was.
- R13: Responses in the same cycle as alloc_i or clear_i are dropped with no event and no error. err_o stays set until the next allocate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_i | input | 1 | Open a new tally with pending value 0 |
| clear_i | input | 1 | Abandon the tally and return to idle |
| data_vld_i | input | 1 | Data response present |
| data_cnt_i | input | CNT_W | Signed ack count carried by the data response |
| ack_vld_i | input | 1 | Single acknowledgement present |
| busy_o | output | 1 | Tally open |
| pending_o | output | CNT_W | Signed pending value |
| evt_vld_o | output | 1 | Event code valid this cycle |
| evt_code_o | output | 3 | Classified event (codes in R3 to R11) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky error flag |

## Verification
On every cycle the assertions check the following: completion never repeats on consecutive cycles and always coincides with idle, the pending value stays inside its signed range, an allocate yields a clean open tally, a response while idle is refused with the error flag, and an open acknowledgement lowers the tally by exactly one. Some behaviours depend on the order of responses, and only the bench scenarios can show them. These are acknowledgements that overtake their data and then close on a data count that cancels them, the choice between the closing and open codes for each response, range refusals at both ends, and the sticky error surviving a clear but not an allocate.

// File: rtl/ackacc_pkg.sv
package ackacc_pkg;

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_DATA_DONE = 3'd1,
        EV_DATA_OPEN = 3'd2,
        EV_DATA_LAST = 3'd3,
        EV_ACK_OPEN  = 3'd4,
        EV_ACK_LAST  = 3'd5,
        EV_PROTO_ERR = 3'd6,
        EV_RANGE_ERR = 3'd7
    } evt_t;

endpackage

// File: rtl/ackacc_range.sv
module ackacc_range #(
    parameter int W     = 6,
    parameter int LIMIT = 15
) (
    input  logic signed [W-1:0] val_i,
    output logic                ok_o
);
    localparam logic signed [W-1:0] HI = W'(LIMIT);
    localparam logic signed [W-1:0] LO = -HI;

    always_comb begin
        ok_o = (val_i <= HI) && (val_i >= LO);
    end
endmodule

// File: rtl/ackacc_classify.sv
module ackacc_classify
    import ackacc_pkg::*;
#(
    parameter int CNT_W       = 5,
    parameter int MAX_SHARERS = 15
) (
    input  logic                    busy_i,
    input  logic signed [CNT_W-1:0] pend_i,
    input  logic                    data_vld_i,
    input  logic signed [CNT_W-1:0] data_cnt_i,
    input  logic                    ack_vld_i,
    output evt_t                    code_o,
    output logic signed [CNT_W-1:0] pend_o,
    output logic                    final_o
);
    localparam int WIDE_W = CNT_W + 1;
    localparam logic signed [WIDE_W-1:0] ONE_W = 1;
    localparam logic signed [CNT_W-1:0]  ONE_N = 1;

    logic signed [WIDE_W-1:0] pend_w;
    logic signed [WIDE_W-1:0] cnt_w;
    logic signed [WIDE_W-1:0] sum_w;
    logic signed [WIDE_W-1:0] dec_w;
    logic                     sum_ok;
    logic                     dec_ok;

    always_comb begin
        pend_w = {pend_i[CNT_W-1], pend_i};
        cnt_w  = {data_cnt_i[CNT_W-1], data_cnt_i};
        sum_w  = pend_w + cnt_w;
        dec_w  = pend_w - ONE_W;
    end

    ackacc_range #(.W(WIDE_W), .LIMIT(MAX_SHARERS)) u_sum_rng (
        .val_i (sum_w),
        .ok_o  (sum_ok)
    );

    ackacc_range #(.W(WIDE_W), .LIMIT(MAX_SHARERS)) u_dec_rng (
        .val_i (dec_w),
        .ok_o  (dec_ok)
    );

    always_comb begin
        code_o  = EV_NONE;
        pend_o  = pend_i;
        final_o = 1'b0;
        if (!data_vld_i && !ack_vld_i) begin
            code_o = EV_NONE;
        end else if ((data_vld_i && ack_vld_i) || !busy_i) begin
            code_o = EV_PROTO_ERR;
        end else if (data_vld_i) begin
            if (data_cnt_i == '0) begin
                code_o  = EV_DATA_DONE;
                pend_o  = '0;
                final_o = 1'b1;
            end else if (sum_w == '0) begin
                code_o  = EV_DATA_LAST;
                pend_o  = '0;
                final_o = 1'b1;
            end else if (!sum_ok) begin
                code_o = EV_RANGE_ERR;
            end else begin
                code_o = EV_DATA_OPEN;
                pend_o = sum_w[CNT_W-1:0];
            end
        end else begin
            if (pend_i == ONE_N) begin
                code_o  = EV_ACK_LAST;
                pend_o  = '0;
                final_o = 1'b1;
            end else if (!dec_ok) begin
                code_o = EV_RANGE_ERR;
            end else begin
                code_o = EV_ACK_OPEN;
                pend_o = dec_w[CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/ack_count_accum.sv
module ack_count_accum
    import ackacc_pkg::*;
#(
    parameter int MAX_SHARERS = 15,
    parameter int CNT_W       = $clog2(MAX_SHARERS + 1) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    alloc_i,
    input  logic                    clear_i,
    input  logic                    data_vld_i,
    input  logic signed [CNT_W-1:0] data_cnt_i,
    input  logic                    ack_vld_i,
    output logic                    busy_o,
    output logic signed [CNT_W-1:0] pending_o,
    output logic                    evt_vld_o,
    output logic [2:0]              evt_code_o,
    output logic                    done_o,
    output logic                    err_o
);
    localparam logic signed [CNT_W-1:0] PEND_HI = CNT_W'(MAX_SHARERS);

    typedef struct packed {
        logic                    busy;
        logic signed [CNT_W-1:0] pend;
        logic                    evt_vld;
        evt_t                    code;
        logic                    done;
        logic                    err;
    } st_t;

    st_t                     st_d, st_q;
    evt_t                    cls_code;
    logic signed [CNT_W-1:0] cls_pend;
    logic                    cls_final;

    ackacc_classify #(.CNT_W(CNT_W), .MAX_SHARERS(MAX_SHARERS)) u_cls (
        .busy_i     (st_q.busy),
        .pend_i     (st_q.pend),
        .data_vld_i (data_vld_i),
        .data_cnt_i (data_cnt_i),
        .ack_vld_i  (ack_vld_i),
        .code_o     (cls_code),
        .pend_o     (cls_pend),
        .final_o    (cls_final)
    );

    always_comb begin
        st_d         = st_q;
        st_d.evt_vld = 1'b0;
        st_d.code    = EV_NONE;
        st_d.done    = 1'b0;
        if (clear_i) begin
            st_d.busy = 1'b0;
            st_d.pend = '0;
        end else if (alloc_i) begin
            st_d.busy = 1'b1;
            st_d.pend = '0;
            st_d.err  = 1'b0;
        end else if (cls_code != EV_NONE) begin
            st_d.evt_vld = 1'b1;
            st_d.code    = cls_code;
            st_d.pend    = cls_pend;
            if (cls_final) begin
                st_d.done = 1'b1;
                st_d.busy = 1'b0;
            end
            if (cls_code == EV_PROTO_ERR || cls_code == EV_RANGE_ERR) begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, pend: '0, evt_vld: 1'b0, code: EV_NONE,
                      done: 1'b0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.busy;
    assign pending_o  = st_q.pend;
    assign evt_vld_o  = st_q.evt_vld;
    assign evt_code_o = st_q.code;
    assign done_o     = st_q.done;
    assign err_o      = st_q.err;

    // R8
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && pending_o == '0));

    // R10
    pend_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o <= PEND_HI) && (pending_o >= -PEND_HI));

    // R2
    alloc_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !clear_i) |=> (busy_o && pending_o == '0 && !err_o && !evt_vld_o));

    // R9
    idle_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !alloc_i && !clear_i && (data_vld_i || ack_vld_i))
        |=> (err_o && !busy_o && evt_code_o == EV_PROTO_ERR && pending_o == $past(pending_o)));

    // R7
    ack_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ack_vld_i && !data_vld_i && !alloc_i && !clear_i
         && pending_o != 1 && pending_o > -PEND_HI)
        |=> (pending_o == $past(pending_o) - 1));
endmodule

// File: tb/ack_count_accum_bench.sv
module ack_count_accum_bench;
    localparam int MAXS  = 15;
    localparam int CNT_W = 5;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    alloc_i = 1'b0;
    logic                    clear_i = 1'b0;
    logic                    data_vld_i = 1'b0;
    logic signed [CNT_W-1:0] data_cnt_i = '0;
    logic                    ack_vld_i = 1'b0;
    logic                    busy_o;
    logic signed [CNT_W-1:0] pending_o;
    logic                    evt_vld_o;
    logic [2:0]              evt_code_o;
    logic                    done_o;
    logic                    err_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model state
    bit    m_busy = 1'b0;
    int    m_pend = 0;
    bit    m_err = 1'b0;
    bit    e_vld;
    int    e_code;
    bit    e_done;
    string e_tag;

    always #10 clk = ~clk;

    ack_count_accum #(.MAX_SHARERS(MAXS)) u_ack_count_accum (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .clear_i(clear_i),
        .data_vld_i(data_vld_i), .data_cnt_i(data_cnt_i), .ack_vld_i(ack_vld_i),
        .busy_o(busy_o), .pending_o(pending_o), .evt_vld_o(evt_vld_o),
        .evt_code_o(evt_code_o), .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic bit out_of_range(input int v);
        return (v > MAXS) || (v < -MAXS);
    endfunction

    task automatic model(input bit a, input bit c, input bit dv, input int dc, input bit av);
        int s;
        e_vld = 0; e_code = 0; e_done = 0; e_tag = "R8";
        if (c) begin
            m_busy = 0; m_pend = 0;
            e_tag = (dv || av) ? "R13" : "R12";
        end else if (a) begin
            m_busy = 1; m_pend = 0; m_err = 0;
            e_tag = (dv || av) ? "R13" : "R2";
        end else if (dv || av) begin
            e_vld = 1;
            if (dv && av) begin
                e_code = 6; m_err = 1; e_tag = "R11";
            end else if (!m_busy) begin
                e_code = 6; m_err = 1; e_tag = "R9";
            end else if (dv) begin
                s = m_pend + dc;
                if (dc == 0) begin
                    e_code = 1; e_done = 1; e_tag = "R3";
                end else if (s == 0) begin
                    e_code = 3; e_done = 1; e_tag = "R4";
                end else if (out_of_range(s)) begin
                    e_code = 7; m_err = 1; e_tag = "R10";
                end else begin
                    e_code = 2; m_pend = s; e_tag = "R5";
                end
            end else begin
                s = m_pend - 1;
                if (m_pend == 1) begin
                    e_code = 5; e_done = 1; e_tag = "R6";
                end else if (out_of_range(s)) begin
                    e_code = 7; m_err = 1; e_tag = "R10";
                end else begin
                    e_code = 4; m_pend = s; e_tag = "R7";
                end
            end
            if (e_done) begin
                m_busy = 0; m_pend = 0;
            end
        end
    endtask

    // called at a negedge: drive, let one edge pass, check at the next negedge
    task automatic step(input bit a, input bit c, input bit dv, input int dc, input bit av);
        alloc_i = a; clear_i = c; data_vld_i = dv; ack_vld_i = av;
        data_cnt_i = CNT_W'(dc);
        model(a, c, dv, dc, av);
        @(negedge clk);
        alloc_i = 0; clear_i = 0; data_vld_i = 0; ack_vld_i = 0; data_cnt_i = '0;
        chk(e_tag, "evt_vld", int'(evt_vld_o), int'(e_vld));
        chk(e_tag, "evt_code", int'(evt_code_o), e_code);
        chk(e_tag, "done", int'(done_o), int'(e_done));
        chk(e_tag, "busy", int'(busy_o), int'(m_busy));
        chk(e_tag, "pending", int'(pending_o), m_pend);
        chk(e_tag, "err", int'(err_o), int'(m_err));
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", int'(busy_o), 0);
        chk("R1", "pending", int'(pending_o), 0);
        chk("R1", "done", int'(done_o), 0);
        chk("R1", "err", int'(err_o), 0);
        chk("R1", "evt_vld", int'(evt_vld_o), 0);
        chk("R1", "evt_code", int'(evt_code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 ack while idle
        step(0, 0, 0, 0, 1);
        // R2 alloc clears the error
        step(1, 0, 0, 0, 0);
        // R3 zero count closes at once
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        // R7 acks overtake data, then R4 data closes
        step(1, 0, 0, 0, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 2, 0);
        // R5 then R6
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 3, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        // R10 upper bound
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 15, 0);
        step(0, 0, 1, 1, 0);
        // R10 lower bound
        step(1, 0, 0, 0, 0);
        for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 1);
        step(0, 0, 1, 15, 0);
        // R11 simultaneous, R13 dropped with alloc, R12 clear keeps err
        step(1, 0, 0, 0, 0);
        step(0, 0, 1, 2, 1);
        step(0, 1, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        step(1, 0, 1, 4, 0);
        step(1, 1, 0, 0, 0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            int r;
            int dc;
            r = int'($urandom_range(0, 15));
            dc = int'($urandom_range(0, 8)) - 3;
            if ($urandom_range(0, 7) == 0) dc = int'($urandom_range(0, 31)) - 16;
            case (r)
                0, 1:          step(1, 0, 0, 0, 0);
                2:             step(0, 1, 0, 0, 0);
                3, 4, 5, 6, 7: step(0, 0, 0, 0, 1);
                8, 9, 10, 11:  step(0, 0, 1, dc, 0);
                12:            step(0, 0, 1, dc, 1);
                13:            step(1, 0, $urandom_range(0, 1) == 1, dc, 0);
                default:       step(0, 0, 0, 0, 0);
            endcase
        end
        report();
    end
endmodule